// File: doc/BRIEF.md
# Link Disable-State Rate Fallback Controller

This block sits on the downstream side of a serial link that can signal at a base rate or a doubled rate. It follows a reduced training state machine with three states: Detect, Active and Disable. Upper-layer commands move the link between them. While the link is Active, a separate command can raise the rate-select output to the high rate.

When the link is sent to Disable while it runs at the high rate, the block drops the rate select back to the base rate by itself. It waits for the PHY to acknowledge the rate change. It then treats a received comma control symbol as the electrical-idle-exit event that returns the link to Detect. This lets the block recognise comma symbols that the upstream partner sends at the base rate.

The block also produces the electrical-idle indication for the upper layer. When inference is off, this indication is the inverse of the receiver's signal-detect flag. When inference is on, the indication is raised after a programmable run of cycles with no valid symbol.

Top module: `link_rate_fallback`

## Requirements
- R1: While reset is held and on the first cycle after reset, `link_state` is 2'b00 (Detect) and `rate_sel` is low.
- R2: `link_state` uses the encoding 2'b00 Detect, 2'b01 Active, 2'b10 Disable and never shows 2'b11. `cmd_train` in Detect moves the state to Active on the next clock edge.
- R3: `cmd_disable` in Detect or Active moves the state to Disable on the next edge. It takes priority over `cmd_train` and `cmd_rate_up` in the same cycle.
- R4: `rate_sel` (high = 5 Gbps, low = 2.5 Gbps) rises on the edge after `cmd_rate_up` only when the state is Active. The command has no effect in Detect or Disable, and `rate_sel` is only ever high in Active.
- R5: Entering Disable while `rate_sel` is high clears `rate_sel` on the same edge that changes the state to Disable.
- R6: A comma is a cycle with `sym_valid` high, `sym_is_k` high and `sym_data` equal to 8'hBC. Any other symbol, including 8'hBC without the K flag or a K symbol with another byte, leaves the state in Disable.
- R7: After Disable is entered from the high rate, commas are ignored up to and including the cycle of the one-cycle `rate_done` pulse. From the next cycle on they are accepted.
- R8: After Disable is entered at the base rate, a comma is accepted from the first cycle spent in Disable.
- R9: An accepted comma moves the state from Disable to Detect on the next edge. Disable never leads to any other state.
- R10: With `infer_en` low, `elec_idle` equals the inverse of `sig_detect` in the same cycle.
- R11: With `infer_en` high, `elec_idle` is high once `idle_limit` consecutive clock edges have passed with `sym_valid` low. It goes low on the edge that samples `sym_valid` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_train | input | 1 | Upper-layer command: Detect to Active |
| cmd_disable | input | 1 | Upper-layer command: go to Disable |
| cmd_rate_up | input | 1 | Upper-layer request for the high rate |
| rate_done | input | 1 | One-cycle PHY acknowledge of a completed rate change |
| sig_detect | input | 1 | Receiver signal-detect flag |
| sym_valid | input | 1 | Decoded symbol valid |
| sym_is_k | input | 1 | Decoded symbol is a control character |
| sym_data | input | 8 | Decoded symbol byte |
| infer_en | input | 1 | Enables electrical-idle inference |
| idle_limit | input | IDLE_W | Cycles without a valid symbol before idle is inferred |
| rate_sel | output | 1 | Rate select, high = 5 Gbps |
| link_state | output | 2 | Current state encoding |
| elec_idle | output | 1 | Electrical-idle indication |

## Verification
The checker assumes that `idle_limit` is at least one and that it does not change while inference is enabled. Without this, a valid symbol could not be guaranteed to clear the idle indication on the following cycle. It also assumes that `rate_done` arrives only while the block is waiting for a rate change. The stimulus holds `idle_limit` at four for the whole run and pulses `rate_done` only in Disable after a high-rate entry. Commands stay legal otherwise, but they are sometimes issued together to exercise priority.

// File: rtl/lrf_pkg.sv
// Shared types and constants for the rate-fallback controller.
// Assumes an 8b/10b decoder upstream that presents bytes plus a K flag.
package lrf_pkg;
    typedef enum logic [1:0] {
        ST_DETECT  = 2'b00,
        ST_ACTIVE  = 2'b01,
        ST_DISABLE = 2'b10
    } lrf_state_e;

    localparam int unsigned SYM_W = 8;
    localparam logic [SYM_W-1:0] COMMA_BYTE = 8'hBC;
endpackage

// File: rtl/lrf_comma_match.sv
// Flags a valid control symbol whose byte equals the comma code.
// Assumes sym_data and sym_is_k are qualified by sym_valid.
module lrf_comma_match #(
    parameter int unsigned SYM_W = 8,
    parameter logic [SYM_W-1:0] MATCH = 8'hBC
) (
    input  logic             sym_valid,
    input  logic             sym_is_k,
    input  logic [SYM_W-1:0] sym_data,
    output logic             hit
);
    // Purpose: combinational compare of the decoded symbol against the comma.
    always_comb begin
        hit = sym_valid && sym_is_k && (sym_data == MATCH);
    end
endmodule

// File: rtl/lrf_state_ctrl.sv
// Reduced link state machine with rate control and Disable-exit arming.
// Assumes rate_done pulses for one cycle after rate_sel falls.
module lrf_state_ctrl
    import lrf_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cmd_train,
    input  logic       cmd_disable,
    input  logic       cmd_rate_up,
    input  logic       rate_done,
    input  logic       comma_hit,
    output lrf_state_e state,
    output logic       rate_sel
);
    lrf_state_e state_nx;
    logic       rate_nx;
    logic       armed, armed_nx;

    // Purpose: next-state, next-rate and exit-arming decisions.
    always_comb begin
        state_nx = state;
        rate_nx  = rate_sel;
        armed_nx = armed;
        unique case (state)
            ST_DETECT: begin
                if (cmd_disable) begin
                    state_nx = ST_DISABLE;
                    armed_nx = !rate_sel;
                    rate_nx  = 1'b0;
                end else if (cmd_train) begin
                    state_nx = ST_ACTIVE;
                end
            end
            ST_ACTIVE: begin
                if (cmd_disable) begin
                    state_nx = ST_DISABLE;
                    armed_nx = !rate_sel;
                    rate_nx  = 1'b0;
                end else if (cmd_rate_up) begin
                    rate_nx = 1'b1;
                end
            end
            ST_DISABLE: begin
                if (armed && comma_hit) begin
                    state_nx = ST_DETECT;
                    armed_nx = 1'b0;
                end else if (!armed && rate_done) begin
                    armed_nx = 1'b1;
                end
            end
            default: begin
                state_nx = ST_DETECT;
                rate_nx  = 1'b0;
                armed_nx = 1'b0;
            end
        endcase
    end

    // Purpose: register state, rate select and arming flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_DETECT;
            rate_sel <= 1'b0;
            armed    <= 1'b0;
        end else begin
            state    <= state_nx;
            rate_sel <= rate_nx;
            armed    <= armed_nx;
        end
    end
endmodule

// File: rtl/lrf_idle_mon.sv
// Electrical-idle indication: inferred from a symbol gap, or the inverse
// of signal detect. Assumes idle_limit >= 1 while inference is enabled.
module lrf_idle_mon #(
    parameter int unsigned CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sym_valid,
    input  logic             infer_en,
    input  logic             sig_detect,
    input  logic [CNT_W-1:0] idle_limit,
    output logic             elec_idle
);
    logic [CNT_W-1:0] gap;

    // Purpose: count cycles since the last valid symbol, saturating at the limit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gap <= '0;
        end else if (sym_valid) begin
            gap <= '0;
        end else if (gap < idle_limit) begin
            gap <= gap + 1'b1;
        end
    end

    // Purpose: select the idle source.
    always_comb begin
        elec_idle = infer_en ? (gap >= idle_limit) : !sig_detect;
    end
endmodule

// File: rtl/link_rate_fallback.sv
// Top: downstream link controller that falls back to the base rate on
// Disable and leaves Disable on a base-rate comma.
// Assumes all inputs are synchronous to clk.
module link_rate_fallback
    import lrf_pkg::*;
#(
    parameter int unsigned IDLE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_train,
    input  logic              cmd_disable,
    input  logic              cmd_rate_up,
    input  logic              rate_done,
    input  logic              sig_detect,
    input  logic              sym_valid,
    input  logic              sym_is_k,
    input  logic [SYM_W-1:0]  sym_data,
    input  logic              infer_en,
    input  logic [IDLE_W-1:0] idle_limit,
    output logic              rate_sel,
    output logic [1:0]        link_state,
    output logic              elec_idle
);
    logic       comma_hit;
    lrf_state_e state;

    lrf_comma_match #(.SYM_W(SYM_W), .MATCH(COMMA_BYTE)) u_comma (
        .sym_valid (sym_valid),
        .sym_is_k  (sym_is_k),
        .sym_data  (sym_data),
        .hit       (comma_hit)
    );

    lrf_state_ctrl u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .cmd_train   (cmd_train),
        .cmd_disable (cmd_disable),
        .cmd_rate_up (cmd_rate_up),
        .rate_done   (rate_done),
        .comma_hit   (comma_hit),
        .state       (state),
        .rate_sel    (rate_sel)
    );

    lrf_idle_mon #(.CNT_W(IDLE_W)) u_idle (
        .clk        (clk),
        .rst_n      (rst_n),
        .sym_valid  (sym_valid),
        .infer_en   (infer_en),
        .sig_detect (sig_detect),
        .idle_limit (idle_limit),
        .elec_idle  (elec_idle)
    );

    // Purpose: expose the state encoding as a plain vector.
    always_comb begin
        link_state = state;
    end
endmodule

// File: rtl/lrf_checker.sv
// Property checker for link_rate_fallback, attached with bind.
// Assumes idle_limit >= 1 and rate_done only while awaiting a rate change.
module lrf_checker #(
    parameter int unsigned IDLE_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cmd_disable,
    input logic              cmd_rate_up,
    input logic              sig_detect,
    input logic              sym_valid,
    input logic              sym_is_k,
    input logic [7:0]        sym_data,
    input logic              infer_en,
    input logic [IDLE_W-1:0] idle_limit,
    input logic              rate_sel,
    input logic [1:0]        link_state,
    input logic              elec_idle
);
    // R2
    legal_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
        link_state != 2'b11);

    // R4
    rate_only_active_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rate_sel |-> link_state == 2'b01);

    // R4
    rate_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rate_sel) |-> ($past(link_state) == 2'b01 && $past(cmd_rate_up)));

    // R5
    rate_fallback_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (link_state == 2'b01 && cmd_disable && rate_sel) |=> (link_state == 2'b10 && !rate_sel));

    // R6
    non_comma_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (link_state == 2'b10 && !(sym_valid && sym_is_k && sym_data == 8'hBC))
        |=> link_state == 2'b10);

    // R9
    disable_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (link_state == 2'b10) |=> (link_state == 2'b10 || link_state == 2'b00));

    // R10
    idle_passthru_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !infer_en |-> (elec_idle == !sig_detect));

    // R11
    idle_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (infer_en && sym_valid && idle_limit != '0 && $stable(idle_limit))
        |=> (!infer_en || !elec_idle));
endmodule

bind link_rate_fallback lrf_checker #(.IDLE_W(IDLE_W)) u_lrf_checker (
    .clk         (clk),
    .rst_n       (rst_n),
    .cmd_disable (cmd_disable),
    .cmd_rate_up (cmd_rate_up),
    .sig_detect  (sig_detect),
    .sym_valid   (sym_valid),
    .sym_is_k    (sym_is_k),
    .sym_data    (sym_data),
    .infer_en    (infer_en),
    .idle_limit  (idle_limit),
    .rate_sel    (rate_sel),
    .link_state  (link_state),
    .elec_idle   (elec_idle)
);

// File: tb/link_rate_fallback_bench.sv
// Bench: behavioural reference model compared every cycle, plus directed
// checks per requirement.
module link_rate_fallback_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cmd_train = 0, cmd_disable = 0, cmd_rate_up = 0, rate_done = 0;
    logic       sig_detect = 1, sym_valid = 0, sym_is_k = 0, infer_en = 0;
    logic [7:0] sym_data = 8'h00;
    logic [7:0] idle_limit = 8'd4;
    logic       rate_sel, elec_idle;
    logic [1:0] link_state;

    int tests = 0;
    int fails = 0;
    int cycles = 0;

    // reference model state
    int m_state = 0;
    int m_rate = 0;
    int m_armed = 0;
    int m_gap = 0;

    always #10 clk = ~clk;

    link_rate_fallback u_link_rate_fallback (
        .clk(clk), .rst_n(rst_n), .cmd_train(cmd_train), .cmd_disable(cmd_disable),
        .cmd_rate_up(cmd_rate_up), .rate_done(rate_done), .sig_detect(sig_detect),
        .sym_valid(sym_valid), .sym_is_k(sym_is_k), .sym_data(sym_data),
        .infer_en(infer_en), .idle_limit(idle_limit), .rate_sel(rate_sel),
        .link_state(link_state), .elec_idle(elec_idle)
    );

    task automatic check(input string tag, input int act, input int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Behavioural model updated on each rising edge.
    always @(posedge clk) begin
        cycles++;
        if (!rst_n) begin
            m_state = 0; m_rate = 0; m_armed = 0; m_gap = 0;
        end else begin
            bit comma;
            comma = sym_valid && sym_is_k && sym_data == 8'hBC;
            if (m_state == 0) begin
                if (cmd_disable) begin m_state = 2; m_armed = (m_rate == 0); m_rate = 0; end
                else if (cmd_train) m_state = 1;
            end else if (m_state == 1) begin
                if (cmd_disable) begin m_state = 2; m_armed = (m_rate == 0); m_rate = 0; end
                else if (cmd_rate_up) m_rate = 1;
            end else begin
                if (m_armed != 0 && comma) begin m_state = 0; m_armed = 0; end
                else if (m_armed == 0 && rate_done) m_armed = 1;
            end
            if (sym_valid) m_gap = 0;
            else if (m_gap < int'(idle_limit)) m_gap++;
        end
    end

    // Per-cycle comparison at the falling edge.
    always @(negedge clk) begin
        if (rst_n) begin
            check("R2 state vs model", int'(link_state), m_state);
            check("R4 rate vs model", int'(rate_sel), m_rate);
            if (infer_en) check("R11 idle vs model", int'(elec_idle), (m_gap >= int'(idle_limit)) ? 1 : 0);
            else          check("R10 idle vs model", int'(elec_idle), sig_detect ? 0 : 1);
        end
    end

    // Watchdog
    always @(posedge clk) begin
        if (cycles > 20000) begin
            fails++;
            $display("FAIL watchdog actual=%0d expected=<20000 cycles", cycles);
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    task automatic tick();
        @(negedge clk);
        #1;
    endtask

    task automatic clear_in();
        cmd_train = 0; cmd_disable = 0; cmd_rate_up = 0; rate_done = 0;
        sym_valid = 0; sym_is_k = 0; sym_data = 8'h00;
    endtask

    task automatic symbol(input logic k, input logic [7:0] d);
        sym_valid = 1; sym_is_k = k; sym_data = d;
    endtask

    initial begin
        repeat (3) tick();
        check("R1 state in reset", int'(link_state), 0);
        check("R1 rate in reset", int'(rate_sel), 0);
        rst_n = 1;
        tick();
        check("R1 state after reset", int'(link_state), 0);
        check("R1 rate after reset", int'(rate_sel), 0);

        // R4: rate request ignored in Detect
        cmd_rate_up = 1; tick(); clear_in();
        check("R4 rate_up in Detect ignored", int'(rate_sel), 0);

        // R2: train to Active
        cmd_train = 1; tick(); clear_in();
        check("R2 Detect->Active", int'(link_state), 1);

        // R4: rate request in Active
        cmd_rate_up = 1; tick(); clear_in();
        check("R4 rate_up in Active", int'(rate_sel), 1);

        // R3 R5: disable at high rate, priority over rate_up
        cmd_disable = 1; cmd_rate_up = 1; tick(); clear_in();
        check("R3 Active->Disable", int'(link_state), 2);
        check("R5 rate dropped", int'(rate_sel), 0);

        // R7: comma before rate_done ignored
        symbol(1, 8'hBC); tick(); clear_in();
        check("R7 comma before rate_done", int'(link_state), 2);
        // R7: comma in same cycle as rate_done ignored
        rate_done = 1; symbol(1, 8'hBC); tick(); clear_in();
        check("R7 comma with rate_done", int'(link_state), 2);
        // R4: rate request in Disable ignored
        cmd_rate_up = 1; tick(); clear_in();
        check("R4 rate_up in Disable ignored", int'(rate_sel), 0);

        // R6: non-comma symbols ignored when armed
        symbol(0, 8'hBC); tick(); clear_in();
        check("R6 BC without K", int'(link_state), 2);
        symbol(1, 8'h3C); tick(); clear_in();
        check("R6 K with other byte", int'(link_state), 2);
        sym_valid = 0; sym_is_k = 1; sym_data = 8'hBC; tick(); clear_in();
        check("R6 comma not valid", int'(link_state), 2);

        // R9: comma exits to Detect
        symbol(1, 8'hBC); tick(); clear_in();
        check("R9 Disable->Detect", int'(link_state), 0);

        // R3: disable from Detect wins over train
        cmd_disable = 1; cmd_train = 1; tick(); clear_in();
        check("R3 Detect->Disable priority", int'(link_state), 2);
        // R8: base-rate entry, comma accepted at once
        symbol(1, 8'hBC); tick(); clear_in();
        check("R8 immediate comma exit", int'(link_state), 0);

        // R11: inference on, gap of idle_limit cycles
        infer_en = 1;
        symbol(0, 8'h4A); tick(); clear_in();
        check("R11 cleared after valid", int'(elec_idle), 0);
        repeat (3) tick();
        check("R11 not yet idle at 3", int'(elec_idle), 0);
        tick();
        check("R11 idle at limit", int'(elec_idle), 1);
        symbol(0, 8'h11); tick(); clear_in();
        check("R11 cleared by symbol", int'(elec_idle), 0);

        // R10: inference off follows inverse signal detect
        infer_en = 0; sig_detect = 0; #1;
        check("R10 no signal -> idle", int'(elec_idle), 1);
        sig_detect = 1; #1;
        check("R10 signal -> not idle", int'(elec_idle), 0);

        // R2 R5: a second high-rate round trip
        cmd_train = 1; tick(); clear_in();
        cmd_rate_up = 1; tick(); clear_in();
        cmd_disable = 1; tick(); clear_in();
        check("R5 second fallback", int'(rate_sel), 0);
        tick();
        rate_done = 1; tick(); clear_in();
        symbol(1, 8'hBC); tick(); clear_in();
        check("R9 second exit", int'(link_state), 0);
        repeat (4) tick();

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule